// File: doc/BRIEF.md
# Logarithmic-Domain Complex Multiplier

This block forms the product of two complex operands, (a + jb) and (c + jd), without any hardware multiplier for the operand data. Each of the four real components enters as a sign-magnitude word. Its magnitude is turned into a base-two logarithm: a priority encoder finds the integer part, and the bits below the leading one give the fraction. A piecewise-linear correction term is added to that fraction. Two log values are summed to form each of the four cross products ac, bd, ad and bc. Each sum passes through an anti-log converter, which subtracts a matching correction and then shifts. The signs and zero operands travel beside the log path.

A final subtractor gives the real part ac − bd, and a final adder gives the imaginary part ad + bc. The results are wide two's-complement words. Operands are accepted on any cycle with `in_valid` high, one set per cycle. A matching `out_valid` pulse comes out a fixed number of cycles later, in the same order as the inputs.

Top module: `log_cplx_mul`

## Requirements
- R1: A result appears with `out_valid` high exactly 4 clock cycles after its operands were sampled with `in_valid` high. `out_valid` is never high without such an input.
- R2: While `rst_n` is low, `out_valid` is low. It stays low after reset until the first input arrives.
- R3: When every nonzero operand magnitude is a power of two, `re` and `im` equal the exact complex product.
- R4: An operand whose magnitude bits are all zero makes both products it takes part in exactly zero, whatever its sign bit (bit W−1) holds. If both components of one operand are zero, `re` and `im` are zero.
- R5: Inputs are sign-magnitude: bit W−1 is the sign (1 means negative) and bits W−2..0 are the magnitude. Each product takes the exclusive-or of its two operand signs. `re` and `im` are two's complement, 2W+1 bits wide.
- R6: For any operands, each output lies within 1% of the sum of the magnitudes of its two exact products, plus 2 units.
- R7: Operand sets given on consecutive cycles yield results on consecutive cycles, in input order, with none lost.
- R8: Operands of the largest magnitude, 2^(W−1)−1, in any sign combination, meet R6 without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on a, b, c, d are valid this cycle |
| a | input | W | Real part of first operand, sign-magnitude |
| b | input | W | Imaginary part of first operand, sign-magnitude |
| c | input | W | Real part of second operand, sign-magnitude |
| d | input | W | Imaginary part of second operand, sign-magnitude |
| out_valid | output | 1 | re and im hold a result this cycle |
| re | output | 2W+1 | Real part ac − bd, two's complement |
| im | output | 2W+1 | Imaginary part ad + bc, two's complement |

## Verification
Both outputs of an operand set are due together, in the fourth cycle after the set is sampled. There is one register each for log conversion, log addition, anti-log conversion and the final add/subtract. The scoreboard stores the cycle number with each expected item and reads outputs on the falling edge. A result that arrives early, arrives late or is not expected at all is reported against R1, and the value checks compare only the item at the head of the queue. Exact checks cover power-of-two and zero operands. All other operand sets are judged against the tolerance of R6.

// File: rtl/log_cplx_mul.sv
`timescale 1ns/1ps
module log_cplx_mul #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  logic [W-1:0]        c,
  input  logic [W-1:0]        d,
  output logic                out_valid,
  output logic signed [2*W:0] re,
  output logic signed [2*W:0] im
);
  localparam int F  = 16;
  localparam int MW = W - 1;
  localparam int LW = $clog2(MW + 1);
  localparam int LV = LW + F;
  localparam int PW = 2 * MW;
  localparam int BW = PW + F + 3;

  function automatic int lnode(input int k);
    case (k)
      1: return 2944;
      2: return 4714;
      3: return 5533;
      4: return 5568;
      5: return 4944;
      6: return 3759;
      7: return 2090;
      default: return 0;
    endcase
  endfunction

  function automatic int anode(input int k);
    case (k)
      1: return 2260;
      2: return 3984;
      3: return 5122;
      4: return 5622;
      5: return 5426;
      6: return 4470;
      7: return 2686;
      default: return 0;
    endcase
  endfunction

  function automatic logic [F-1:0] corr(input logic [F-1:0] x, input logic anti);
    int k, t, n0, n1;
    k  = int'(x[F-1 -: 3]);
    t  = int'(x[F-4:0]);
    n0 = anti ? anode(k) : lnode(k);
    n1 = anti ? anode(k + 1) : lnode(k + 1);
    return F'(n0 + (((n1 - n0) * t) >>> (F - 3)));
  endfunction

  function automatic logic [LV-1:0] to_log(input logic [MW-1:0] m);
    logic [LW-1:0]     p;
    logic [MW-1:0]     nm;
    logic [MW+F-2:0]   ext;
    logic [F-1:0]      fr;
    p = '0;
    for (int i = 0; i < MW; i++)
      if (m[i]) p = LW'(i);
    nm  = m << (MW - 1 - int'(p));
    ext = (MW+F-1)'({nm, F'(0)});
    fr  = F'(ext >> (MW - 1));
    return {p, F'(0)} + LV'(fr) + LV'(corr(fr, 1'b0));
  endfunction

  function automatic logic [PW:0] from_log(input logic [LV:0] s);
    logic [F-1:0]  f;
    logic [LW:0]   n;
    logic [F+1:0]  mt;
    logic [BW-1:0] big;
    f   = s[F-1:0];
    n   = s[LV:F];
    mt  = (F+2)'(1 << F) + (F+2)'(f) - (F+2)'(corr(f, 1'b1));
    big = BW'(mt) << n;
    return (PW+1)'((big + BW'(1 << (F - 1))) >> F);
  endfunction

  function automatic int lft(input int k);
    return k % 2;
  endfunction

  function automatic int rgt(input int k);
    return (k < 2) ? k + 2 : 5 - k;
  endfunction

  logic [W-1:0]          opnd [4];
  logic [LV-1:0]         l1   [4];
  logic [LV:0]           l2   [4];
  logic [PW:0]           mg   [4];
  logic signed [PW+1:0]  p3   [4];
  logic [3:0]            z1, s1, z2, s2;
  logic [3:0]            vld;

  assign opnd[0] = a;
  assign opnd[1] = b;
  assign opnd[2] = c;
  assign opnd[3] = d;
  assign out_valid = vld[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld <= '0;
    else        vld <= {vld[2:0], in_valid};

  always_comb
    for (int k = 0; k < 4; k++) mg[k] = from_log(l2[k]);

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      l1[k] <= to_log(opnd[k][W-2:0]);
      z1[k] <= (opnd[k][W-2:0] == '0);
      s1[k] <= opnd[k][W-1];
    end
    for (int k = 0; k < 4; k++) begin
      l2[k] <= (LV+1)'(l1[lft(k)]) + (LV+1)'(l1[rgt(k)]);
      z2[k] <= z1[lft(k)] | z1[rgt(k)];
      s2[k] <= s1[lft(k)] ^ s1[rgt(k)];
    end
    for (int k = 0; k < 4; k++)
      p3[k] <= z2[k] ? '0 :
               s2[k] ? -$signed({1'b0, mg[k]}) : $signed({1'b0, mg[k]});
    re <= {p3[0][PW+1], p3[0]} - {p3[1][PW+1], p3[1]};
    im <= {p3[2][PW+1], p3[2]} + {p3[3][PW+1], p3[3]};
  end
endmodule

module log_cplx_mul_chk #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [W-1:0]        a,
  input logic [W-1:0]        b,
  input logic [W-1:0]        c,
  input logic [W-1:0]        d,
  input logic                out_valid,
  input logic signed [2*W:0] re,
  input logic signed [2*W:0] im
);
  // R2
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !out_valid);
  // R1
  result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid);
  // R1
  result_caused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));
  // R4
  first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a[W-2:0] == '0 && b[W-2:0] == '0) |-> ##4 (re == '0 && im == '0));
  // R4
  second_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c[W-2:0] == '0 && d[W-2:0] == '0) |-> ##4 (re == '0 && im == '0));
endmodule

bind log_cplx_mul log_cplx_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .a(a), .b(b), .c(c), .d(d),
  .out_valid(out_valid), .re(re), .im(im)
);

// File: tb/log_cplx_mul_bench.sv
`timescale 1ns/1ps
module log_cplx_mul_bench;
  localparam int W  = 32;
  localparam int OW = 2 * W + 1;
  typedef logic signed [2*W+3:0] wd_t;
  typedef struct {
    wd_t er, ei, tr, ti;
    int cyc;
    string tag;
  } item_t;

  logic clk = 1'b0, rst_n, in_valid;
  logic [W-1:0] a, b, c, d;
  logic out_valid;
  logic signed [OW-1:0] re, im;

  item_t q[$];
  item_t mit;
  wd_t are, aim;
  int cyc = 0, nchk = 0, nfail = 0;
  longint unsigned seed = 64'h2545F4914F6CDD1D;

  log_cplx_mul #(.W(W)) u_log_cplx_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a(a), .b(b), .c(c), .d(d),
    .out_valid(out_valid), .re(re), .im(im)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic wd_t dec(input logic [W-1:0] v);
    wd_t m = wd_t'(v[W-2:0]);
    return v[W-1] ? -m : m;
  endfunction

  function automatic wd_t absw(input wd_t v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [W-1:0] sm(input longint v);
    return (v < 0) ? {1'b1, (W-1)'(-v)} : {1'b0, (W-1)'(v)};
  endfunction

  task automatic chk(input bit ok, input string tag, input wd_t act, input wd_t exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] ra, rb, rc, rd, input bit exact, input string tag);
    item_t it;
    wd_t va = dec(ra), vb = dec(rb), vc = dec(rc), vd = dec(rd);
    it.er  = va * vc - vb * vd;
    it.ei  = va * vd + vb * vc;
    it.tr  = exact ? wd_t'(0) : (absw(va * vc) + absw(vb * vd)) / 100 + 2;
    it.ti  = exact ? wd_t'(0) : (absw(va * vd) + absw(vb * vc)) / 100 + 2;
    it.tag = tag;
    @(negedge clk);
    a = ra; b = rb; c = rc; d = rd;
    in_valid = 1'b1;
    it.cyc = cyc;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  function automatic logic [W-1:0] rnd_word();
    logic [W-2:0] m;
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    m = (W-1)'(seed >> 33) >> seed[4:0];
    return {seed[7], m};
  endfunction

  always @(negedge clk)
    if (rst_n && out_valid) begin
      if (q.size() == 0) chk(1'b0, "R1 unexpected out_valid", 1, 0);
      else begin
        mit = q.pop_front();
        are = re;
        aim = im;
        chk(cyc - mit.cyc == 4, {"R1 latency ", mit.tag}, wd_t'(cyc - mit.cyc), 4);
        chk(absw(are - mit.er) <= mit.tr, {mit.tag, " real"}, are, mit.er);
        chk(absw(aim - mit.ei) <= mit.ti, {mit.tag, " imag"}, aim, mit.ei);
      end
    end

  initial begin
    #400000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    a = '0; b = '0; c = '0; d = '0;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 during reset", wd_t'(out_valid), 0);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 after reset", wd_t'(out_valid), 0);
    end

    send(sm(4), sm(2), sm(8), sm(-1), 1'b1, "R3 R5 small powers");
    send(sm(1), sm(-1), sm(1), sm(1), 1'b1, "R3 R5 unit");
    send(sm(-16), sm(32), sm(64), sm(-128), 1'b1, "R3 R5 mixed signs");
    send(sm(64'sd1 <<< 30), sm(64'sd1 <<< 30), sm(64'sd1 <<< 30), sm(-(64'sd1 <<< 30)),
         1'b1, "R3 large powers");
    idle(6);

    send(sm(0), sm(12), sm(7), sm(9), 1'b0, "R4 a zero");
    send({1'b1, {(W-1){1'b0}}}, sm(-13), sm(11), sm(6), 1'b0, "R4 negative zero");
    send(sm(123), sm(-77), sm(0), {1'b1, {(W-1){1'b0}}}, 1'b1, "R4 c and d zero");
    send(sm(0), {1'b1, {(W-1){1'b0}}}, sm(999), sm(-5), 1'b1, "R4 a and b zero");
    idle(6);

    send(sm(3), sm(5), sm(-7), sm(11), 1'b0, "R5 quadrant 2");
    send(sm(-300), sm(-41), sm(-77), sm(19), 1'b0, "R5 quadrant 3");
    send(sm(-123456), sm(654321), sm(1000), sm(-999999), 1'b0, "R5 quadrant 4");
    idle(6);

    for (int i = 0; i < 300; i++) begin
      send(rnd_word(), rnd_word(), rnd_word(), rnd_word(), 1'b0, "R6 R7 stream");
      if (i % 9 == 8) idle(1);
    end
    idle(6);

    send(sm(64'sd2147483647), sm(64'sd2147483647), sm(64'sd2147483647), sm(-64'sd2147483647),
         1'b0, "R8 max a");
    send(sm(-64'sd2147483647), sm(-64'sd2147483647), sm(-64'sd2147483647), sm(-64'sd2147483647),
         1'b0, "R8 max b");
    send(sm(64'sd2147483647), sm(-64'sd2147483647), sm(64'sd2147483647), sm(64'sd2147483647),
         1'b0, "R8 max c");
    idle(10);
    chk(q.size() == 0, "R7 results outstanding", wd_t'(q.size()), 0);
    finish_run();
  end
endmodule